// File: doc/BRIEF.md
# Watchdog Configuration Cross-Domain Updater

This block is the register front end of a free-running watchdog whose counter runs on a slow, independent low-speed oscillator. On the fast bus clock it decodes word writes and reads to four registers: a 16-bit key register, a 3-bit prescaler register, a 12-bit reload register and a read-only status register. The watchdog core that uses the key is not part of this block.

Each write to the prescaler or reload register starts a transfer of the new value into the slow clock domain. The transfer uses a request toggle that crosses into the slow domain and an acknowledge toggle that crosses back. While a transfer is in flight, the busy flag for that field reads as one. Further writes to that field are dropped until the slow domain has taken the value. The transfer depends only on the two clocks and the two resets, so it always runs to completion once started.

Top module: `wdg_cfg_xfer`

## Requirements
- R1: After reset the key register reads 0x0000, prescaler 0, reload 0xFFF and status 0.
- R2: Word offsets are fixed: key at 0x0, prescaler at 0x4, reload at 0x8, status at 0xC. Key reads back in bits 15:0, prescaler in bits 2:0, reload in bits 11:0. Status bit 1 is the reload busy flag and bit 0 is the prescaler busy flag.
- R3: Register bits above each field read as zero. Any offset other than the four listed reads as zero, and a write to it changes no register.
- R4: In the bus cycle after an accepted prescaler or reload write, the matching status bit reads 1.
- R5: A busy flag clears within 5 slow-clock periods plus 3 bus-clock periods of the write edge. When it has cleared, the slow-domain output equals the written value.
- R6: A write to a field whose busy flag is set is discarded. Both the bus-side read-back and the slow-domain value keep the earlier value.
- R7: The two fields are independent: a write to one field never sets the other field's busy flag and never alters the other field's value.
- R8: The status register is read-only. A write to offset 0xC changes neither busy flag.
- R9: After reset the slow-domain outputs are prescaler 0 and reload 0xFFF. They change only when a transfer lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| key_q | output | 16 | Current key register value, bus domain |
| slow_clk | input | 1 | Low-speed oscillator clock |
| slow_rst_n | input | 1 | Slow-domain reset, active low |
| slow_presc | output | 3 | Prescaler value as seen by the slow domain |
| slow_reload | output | 12 | Reload value as seen by the slow domain |

## Verification
The bench runs the two clocks at unrelated periods. It times each busy flag from the write edge to its clearing, so a design that forgets the acknowledge path stays busy forever, and one that clears too early lets the slow output lag the read-back. A second write is issued one cycle after the first. A design that does not gate writes on the busy flag would overwrite the pending value, and the slow domain would then capture a value that was never acknowledged. Writes to the status register, to unmapped offsets and to the other field check that the flags and values do not leak between registers.

// File: rtl/wdg_cfg_pkg.sv
package wdg_cfg_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int KEY_W  = 16;
  localparam int PRE_W  = 3;
  localparam int RLD_W  = 12;

  localparam logic [ADDR_W-1:0] OFF_KEY  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_RLD  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'hC;

  localparam logic [KEY_W-1:0] KEY_RST = '0;
  localparam logic [PRE_W-1:0] PRE_RST = '0;
  localparam logic [RLD_W-1:0] RLD_RST = '1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_KEY, SEL_PRE, SEL_RLD, SEL_STAT
  } reg_sel_e;

  // Offset to register select; unmapped offsets yield SEL_NONE.
  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_KEY:  return SEL_KEY;
      OFF_PRE:  return SEL_PRE;
      OFF_RLD:  return SEL_RLD;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Status word: reload busy in bit 1, prescaler busy in bit 0.
  function automatic logic [BUS_W-1:0] pack_status(input logic rld_busy,
                                                   input logic pre_busy);
    return {{(BUS_W-2){1'b0}}, rld_busy, pre_busy};
  endfunction

  // A transfer is pending while the request and returned acknowledge differ.
  function automatic logic pending(input logic req, input logic ack);
    return req ^ ack;
  endfunction
endpackage

// File: rtl/wdg_tgl_sync.sv
module wdg_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_xfer_chan.sv
module wdg_xfer_chan
  import wdg_cfg_pkg::*;
#(
  parameter int          W           = 3,
  parameter logic [W-1:0] RST_VAL    = '0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic         bus_clk,
  input  logic         bus_rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         busy,
  input  logic         slow_clk,
  input  logic         slow_rst_n,
  output logic [W-1:0] slow_value
);
  logic req_tgl;
  logic ack_tgl;
  logic req_in_slow;
  logic ack_in_bus;
  logic wr_accept;
  logic slow_capture;

  assign busy      = pending(req_tgl, ack_in_bus);
  assign wr_accept = wr_req & ~busy;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      value   <= RST_VAL;
      req_tgl <= 1'b0;
    end else if (wr_accept) begin
      value   <= wdata;
      req_tgl <= ~req_tgl;
    end
  end

  wdg_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_in_slow)
  );

  // value is held stable while busy, so the slow side may sample it here.
  assign slow_capture = pending(req_in_slow, ack_tgl);

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      slow_value <= RST_VAL;
      ack_tgl    <= 1'b0;
    end else if (slow_capture) begin
      slow_value <= value;
      ack_tgl    <= req_in_slow;
    end
  end

  wdg_tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_in_bus)
  );

  assert_busy_after_accept_R4: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) wr_accept |=> busy);

  assert_hold_while_busy_R6: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n) (wr_req && busy) |=> $stable(value));

  assert_slow_moves_on_capture_R9: assert property (
    @(posedge slow_clk) disable iff (!slow_rst_n) !slow_capture |=> $stable(slow_value));
endmodule

// File: rtl/wdg_cfg_decode.sv
module wdg_cfg_decode
  import wdg_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [KEY_W-1:0]  key_val,
  input  logic [PRE_W-1:0]  pre_val,
  input  logic [RLD_W-1:0]  rld_val,
  input  logic              pre_busy,
  input  logic              rld_busy,
  output logic              wr_key,
  output logic              wr_pre,
  output logic              wr_rld,
  output logic [BUS_W-1:0]  rdata
);
  reg_sel_e sel;
  logic     mapped;

  assign sel    = decode_offset(addr);
  assign mapped = (sel != SEL_NONE);
  assign wr_key = we && (sel == SEL_KEY);
  assign wr_pre = we && (sel == SEL_PRE);
  assign wr_rld = we && (sel == SEL_RLD);

  always_comb begin
    case (sel)
      SEL_KEY:  rdata = {{(BUS_W-KEY_W){1'b0}}, key_val};
      SEL_PRE:  rdata = {{(BUS_W-PRE_W){1'b0}}, pre_val};
      SEL_RLD:  rdata = {{(BUS_W-RLD_W){1'b0}}, rld_val};
      SEL_STAT: rdata = pack_status(rld_busy, pre_busy);
      default:  rdata = '0;
    endcase
  end

  assert_one_strobe_R2: assert property (
    @(posedge clk) disable iff (!rst_n) $onehot0({wr_key, wr_pre, wr_rld}));

  assert_unmapped_reads_zero_R3: assert property (
    @(posedge clk) disable iff (!rst_n) !mapped |-> (rdata == '0));
endmodule

// File: rtl/wdg_cfg_xfer.sv
module wdg_cfg_xfer
  import wdg_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  bus_clk,
  input  logic                  bus_rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic [KEY_W-1:0]      key_q,
  input  logic                  slow_clk,
  input  logic                  slow_rst_n,
  output logic [PRE_W-1:0]      slow_presc,
  output logic [RLD_W-1:0]      slow_reload
);
  logic             wr_key, wr_pre, wr_rld;
  logic [PRE_W-1:0] pre_q;
  logic [RLD_W-1:0] rld_q;
  logic             pre_busy, rld_busy;

  wdg_cfg_decode u_dec (
    .clk(bus_clk), .rst_n(bus_rst_n), .addr(bus_addr), .we(bus_we),
    .key_val(key_q), .pre_val(pre_q), .rld_val(rld_q),
    .pre_busy(pre_busy), .rld_busy(rld_busy),
    .wr_key(wr_key), .wr_pre(wr_pre), .wr_rld(wr_rld), .rdata(bus_rdata)
  );

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)  key_q <= KEY_RST;
    else if (wr_key) key_q <= bus_wdata[KEY_W-1:0];
  end

  wdg_xfer_chan #(.W(PRE_W), .RST_VAL(PRE_RST), .SYNC_STAGES(SYNC_STAGES)) u_pre (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_req(wr_pre),
    .wdata(bus_wdata[PRE_W-1:0]), .value(pre_q), .busy(pre_busy),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .slow_value(slow_presc)
  );

  wdg_xfer_chan #(.W(RLD_W), .RST_VAL(RLD_RST), .SYNC_STAGES(SYNC_STAGES)) u_rld (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_req(wr_rld),
    .wdata(bus_wdata[RLD_W-1:0]), .value(rld_q), .busy(rld_busy),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .slow_value(slow_reload)
  );

  assert_status_not_written_R8: assert property (
    @(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_we && bus_addr == OFF_STAT && !pre_busy && !rld_busy) |=> (!pre_busy && !rld_busy));
endmodule

// File: tb/wdg_cfg_xfer_tb.sv
module wdg_cfg_xfer_tb_top;
  localparam int BUS_NS  = 20;
  localparam int SLOW_NS = 170;
  localparam int LIMIT   = (5 * SLOW_NS + 3 * BUS_NS) / BUS_NS;

  logic        bus_clk = 0, slow_clk = 0;
  logic        bus_rst_n = 0, slow_rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] key_q;
  logic [2:0]  slow_presc;
  logic [11:0] slow_reload;

  int n_checks = 0, n_fail = 0;

  always #(BUS_NS/2) bus_clk = ~bus_clk;
  always #(SLOW_NS/2) slow_clk = ~slow_clk;

  wdg_cfg_xfer dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_q(key_q),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .slow_presc(slow_presc), .slow_reload(slow_reload)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge bus_clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Counts bus cycles until the given status bit is clear.
  task automatic wait_clear(input int bitpos, output int cycles);
    logic [31:0] s;
    cycles = 0;
    rd(4'hC, s);
    while (s[bitpos] && cycles < 400) begin
      @(negedge bus_clk);
      cycles++;
      rd(4'hC, s);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); check(d == 32'h0, "R1 key", d, 32'h0);
    rd(4'h4, d); check(d == 32'h0, "R1 presc", d, 32'h0);
    rd(4'h8, d); check(d == 32'hFFF, "R1 reload", d, 32'hFFF);
    rd(4'hC, d); check(d == 32'h0, "R1 status", d, 32'h0);
    check(slow_presc == 3'd0, "R9 slow presc reset", 32'(slow_presc), 0);
    check(slow_reload == 12'hFFF, "R9 slow reload reset", 32'(slow_reload), 32'hFFF);
  endtask

  task automatic t_key;
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_ABCD);
    rd(4'h0, d); check(d == 32'h0000_ABCD, "R2 R3 key readback", d, 32'h0000_ABCD);
    check(key_q == 16'hABCD, "R2 key_q", 32'(key_q), 32'hABCD);
    rd(4'hC, d); check(d == 32'h0, "R7 key write sets no busy", d, 0);
    check(slow_presc == 3'd0 && slow_reload == 12'hFFF, "R9 slow unchanged by key",
          {17'h0, slow_presc, slow_reload}, 32'h0FFF);
  endtask

  task automatic t_presc;
    logic [31:0] d; int c;
    wr(4'h4, 32'hFFFF_FFF5);
    rd(4'hC, d); check(d == 32'h1, "R4 presc busy set", d, 32'h1);
    rd(4'h4, d); check(d == 32'h5, "R2 R3 presc readback", d, 32'h5);
    wait_clear(0, c);
    check(c <= LIMIT, "R5 presc busy clear bound", c, LIMIT);
    check(slow_presc == 3'd5, "R5 slow presc", 32'(slow_presc), 5);
  endtask

  task automatic t_reload;
    logic [31:0] d; int c;
    wr(4'h8, 32'h0000_0123);
    rd(4'hC, d); check(d == 32'h2, "R4 R7 reload busy only", d, 32'h2);
    wait_clear(1, c);
    check(c <= LIMIT, "R5 reload busy clear bound", c, LIMIT);
    check(slow_reload == 12'h123, "R5 slow reload", 32'(slow_reload), 32'h123);
    check(slow_presc == 3'd5, "R7 presc untouched", 32'(slow_presc), 5);
  endtask

  task automatic t_busy_drop;
    logic [31:0] d; int c;
    wr(4'h4, 32'h3);
    wr(4'h4, 32'h6);
    rd(4'h4, d); check(d == 32'h3, "R6 presc write while busy dropped", d, 3);
    wait_clear(0, c);
    check(slow_presc == 3'd3, "R6 slow keeps first presc", 32'(slow_presc), 3);
    wr(4'h8, 32'h0AA);
    wr(4'h8, 32'h055);
    rd(4'h8, d); check(d == 32'h0AA, "R6 reload write while busy dropped", d, 32'h0AA);
    wait_clear(1, c);
    check(slow_reload == 12'h0AA, "R6 slow keeps first reload", 32'(slow_reload), 32'h0AA);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); check(d == 32'h0, "R8 status write ignored", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h6, d); check(d == 32'h0, "R3 unmapped reads zero", d, 0);
    rd(4'h0, d); check(d == 32'hABCD, "R3 key untouched", d, 32'hABCD);
    rd(4'h4, d); check(d == 32'h3, "R3 presc untouched", d, 3);
    rd(4'h8, d); check(d == 32'h0AA, "R3 reload untouched", d, 32'h0AA);
    rd(4'hC, d); check(d == 32'h0, "R3 no busy from unmapped", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge slow_clk);
        bus_rst_n = 1; slow_rst_n = 1;
        @(negedge bus_clk);
        t_reset();
        t_key();
        t_presc();
        t_reload();
        t_busy_drop();
        t_status_ro();
        t_unmapped();
      end
      begin
        repeat (100000) @(posedge bus_clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog timeout actual=0x0 expected=0x1");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule